// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every clock of one read or write burst. It can sit inside a synchronous DRAM model or in a memory controller. A start strobe captures the start column, the burst length and the counting order. From the next clock the block presents one column per cycle and holds a burst-active flag high until the burst ends.

Two counting orders are supported. Sequential counting steps through the aligned block that holds the start column and wraps at its edge. Interleave counting combines the start column with a running count by XOR. A full-page length walks the whole 256-column row and keeps going until the burst is stopped.

A stop strobe ends a burst on any cycle. A new start strobe replaces the running burst on any cycle and begins again from its own start column.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_n is low and in the first cycle after it, burst_active is 0 and col_addr is 0.
- R2: When burst_go is high at a rising edge, burst_active is 1 in the following cycle and col_addr equals the start_col sampled at that edge.
- R3: Sequential bursts of length 2, 4 or 8 add the count to the start column modulo the length. Only the low log2(length) bits change, so the address wraps inside the aligned block (start 5, length 4 gives 5, 6, 7, 4).
- R4: Interleave bursts (ilv_mode = 1) present start_col XOR count, with the count running from 0 to length-1 (start 5, length 8 gives 5, 4, 7, 6, 1, 0, 3, 2).
- R5: A burst of length L keeps burst_active high for exactly L cycles and then clears it. Whenever burst_active is 0, col_addr is 0. Length codes on bl_sel are 0→1, 1→2, 2→4, 3→8.
- R6: A bl_sel value of 4 to 7 with ilv_mode = 0 selects a full-page burst. The address increments modulo 256 (254, 255, 0, 1, ...) and the burst never ends by itself.
- R7: A full-page bl_sel value with ilv_mode = 1 behaves as an interleave burst of length 8.
- R8: burst_stop high at an edge while a burst is active clears burst_active in the next cycle. burst_stop while idle has no effect.
- R9: burst_go during an active burst restarts from the new start_col with the new settings. If burst_go and burst_stop are both high at the same edge, burst_go wins.
- R10: bl_sel and ilv_mode are sampled only with burst_go. Changing them during a burst does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_go | input | 1 | Start a new burst (also interrupts a running one) |
| burst_stop | input | 1 | Terminate the running burst |
| start_col | input | COL_W (8) | First column of the burst |
| bl_sel | input | 3 | Length code: 0..3 = 1,2,4,8 words; 4..7 = full page |
| ilv_mode | input | 1 | 0 = sequential order, 1 = interleave order |
| col_addr | output | COL_W (8) | Column address of the current burst cycle, 0 when idle |
| burst_active | output | 1 | High while a burst is presenting addresses |

## Verification
Directed bursts from an unaligned start column separate sequential wrap from interleave XOR and from a plain increment. A full page started at 254 shows whether the row boundary wraps and whether the burst ends by itself. Random streams mix every length code, both orders, random start columns, stops, mid-burst restarts and mid-burst changes to the settings. These streams expose faults in burst length counting, in the priority of start over stop and in the capture of the settings at start.

// File: rtl/bcg_pkg.sv
// Shared definitions for the burst column generator.
// Assumes a 3-bit length code: 0..3 are power-of-two lengths, 4..7 full page.
package bcg_pkg;

    localparam int BL_SEL_W = 3;

    typedef enum logic { ORD_SEQ = 1'b0, ORD_ILV = 1'b1 } burst_order_e;

    // True when the code asks for a full-page burst that the order permits
    function automatic logic is_full_page(input logic [BL_SEL_W-1:0] sel,
                                          input burst_order_e ord);
        return sel[BL_SEL_W-1] && (ord == ORD_SEQ);
    endfunction

    // log2 of the burst length for finite bursts; interleave full page folds to 8
    function automatic logic [1:0] span_log2(input logic [BL_SEL_W-1:0] sel);
        return sel[BL_SEL_W-1] ? 2'd3 : sel[1:0];
    endfunction

endpackage

// File: rtl/bcg_ctrl.sv
// Burst sequencing state: captures the settings on a start strobe, runs the
// burst counter and decides when the burst ends.
// Assumes COL_W columns per row; a full page spans all 2**COL_W columns.
module bcg_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                stop,
    input  logic [COL_W-1:0]    start_col,
    input  logic [BL_SEL_W-1:0] bl_sel,
    input  logic                ilv_in,
    output logic                active,
    output logic [COL_W-1:0]    cnt,
    output logic [COL_W-1:0]    base,
    output logic [COL_W-1:0]    mask,
    output burst_order_e        order,
    output logic                full
);

    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

    burst_order_e            ord_in;
    logic                    full_in;
    logic [COL_W-1:0]        mask_in;
    logic                    last_beat;

    // Decode the requested settings into a wrap mask and a full-page flag
    always_comb begin
        ord_in  = burst_order_e'(ilv_in);
        full_in = is_full_page(bl_sel, ord_in);
        mask_in = full_in ? ALL_ONES : ~(ALL_ONES << span_log2(bl_sel));
    end

    // Last beat of a finite burst: the counter has reached length minus one
    assign last_beat = !full && (cnt == mask);

    // Burst state register: start wins over stop, stop wins over counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            base   <= '0;
            mask   <= '0;
            order  <= ORD_SEQ;
            full   <= 1'b0;
        end else if (go) begin
            active <= 1'b1;
            cnt    <= '0;
            base   <= start_col;
            mask   <= mask_in;
            order  <= ord_in;
            full   <= full_in;
        end else if (active) begin
            if (stop || last_beat) begin
                active <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcg_map.sv
// Column mapping: turns the captured base column and burst count into the
// address of the current beat in the selected order.
// Assumes mask has ones exactly over the bits that may change in the burst.
module bcg_map
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             active,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] mask,
    input  burst_order_e     order,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;
    logic [COL_W-1:0] sum;

    // Sequential order: add within the masked bits, keep the block bits
    always_comb begin
        sum     = base + cnt;
        seq_col = (base & ~mask) | (sum & mask);
    end

    // Interleave order: flip the masked bits of the base by the count
    assign ilv_col = base ^ (cnt & mask);

    // Output select: idle forces zero
    always_comb begin
        if (!active)                col = '0;
        else if (order == ORD_ILV)  col = ilv_col;
        else                        col = seq_col;
    end

endmodule

// File: rtl/burst_col_gen.sv
// Top level of the burst column address generator. Control state lives in
// bcg_ctrl, address formation in bcg_map. Inputs are sampled on rising clk.
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                burst_go,
    input  logic                burst_stop,
    input  logic [COL_W-1:0]    start_col,
    input  logic [BL_SEL_W-1:0] bl_sel,
    input  logic                ilv_mode,
    output logic [COL_W-1:0]    col_addr,
    output logic                burst_active
);

    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    burst_order_e     order_q;
    logic             full_q;

    bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (burst_go),
        .stop      (burst_stop),
        .start_col (start_col),
        .bl_sel    (bl_sel),
        .ilv_in    (ilv_mode),
        .active    (burst_active),
        .cnt       (cnt_q),
        .base      (base_q),
        .mask      (mask_q),
        .order     (order_q),
        .full      (full_q)
    );

    bcg_map #(.COL_W(COL_W)) u_map (
        .active (burst_active),
        .cnt    (cnt_q),
        .base   (base_q),
        .mask   (mask_q),
        .order  (order_q),
        .col    (col_addr)
    );

endmodule

// File: rtl/bcg_checker.sv
// Property checker for burst_col_gen, attached through bind below.
// Watches the ports plus the captured mask, counter and full-page flag.
module bcg_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             burst_go,
    input logic             burst_stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_addr,
    input logic             burst_active,
    input logic [COL_W-1:0] cnt_q,
    input logic [COL_W-1:0] mask_q,
    input logic             full_q
);

    // Idle output is zero
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> col_addr == '0);

    // Start presents the start column next cycle
    assert_start_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> (burst_active && col_addr == $past(start_col)));

    // Only the masked bits move between beats of one burst
    assert_block_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && $past(burst_active) && !$past(burst_go))
        |-> (((col_addr ^ $past(col_addr)) & ~mask_q) == '0));

    // Full page steps by one modulo the row size
    assert_page_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && full_q && $past(burst_active) && !$past(burst_go))
        |-> col_addr == COL_W'($past(col_addr) + 1'b1));

    // Finite burst ends after its last beat
    assert_burst_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !burst_go && !burst_stop && !full_q && cnt_q == mask_q)
        |=> !burst_active);

    // Stop without start ends the burst
    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && burst_stop && !burst_go) |=> !burst_active);

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_bcg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_go     (burst_go),
    .burst_stop   (burst_stop),
    .start_col    (start_col),
    .col_addr     (col_addr),
    .burst_active (burst_active),
    .cnt_q        (cnt_q),
    .mask_q       (mask_q),
    .full_q       (full_q)
);

// File: tb/test_burst_col_gen.sv
// Bench for burst_col_gen: directed corner bursts followed by seeded random
// traffic, every cycle compared against a reference model kept in the bench.
module test_burst_col_gen;

    localparam int COL_W = 8;
    localparam int ROW   = 256;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             burst_go;
    logic             burst_stop;
    logic [COL_W-1:0] start_col;
    logic [2:0]       bl_sel;
    logic             ilv_mode;
    logic [COL_W-1:0] col_addr;
    logic             burst_active;

    int vectors  = 0;
    int failures = 0;

    // Reference state
    bit m_act;
    int m_cnt;
    int m_base;
    int m_len;   // 0 means full page
    bit m_ilv;

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_go     (burst_go),
        .burst_stop   (burst_stop),
        .start_col    (start_col),
        .bl_sel       (bl_sel),
        .ilv_mode     (ilv_mode),
        .col_addr     (col_addr),
        .burst_active (burst_active)
    );

    function automatic int len_of(input int sel, input bit ilv);
        if (sel < 4) return 1 << sel;
        return ilv ? 8 : 0;
    endfunction

    function automatic int exp_col();
        int blk;
        if (!m_act)     return 0;
        if (m_len == 0) return (m_base + m_cnt) % ROW;
        if (m_ilv)      return m_base ^ m_cnt;
        blk = (m_base / m_len) * m_len;
        return blk + ((m_base % m_len) + m_cnt) % m_len;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    endtask

    // Drive one cycle of inputs, advance the model, compare after the edge
    task automatic step(input bit go, input bit stop, input int col,
                        input int sel, input bit ilv);
        string tag;
        burst_go   = go;
        burst_stop = stop;
        start_col  = COL_W'(col);
        bl_sel     = 3'(sel);
        ilv_mode   = ilv;
        if (go) begin
            m_act = 1; m_cnt = 0; m_base = col;
            m_len = len_of(sel, ilv); m_ilv = (sel < 4) ? ilv : ilv;
        end else if (m_act) begin
            if (stop) m_act = 0;
            else if (m_len != 0 && m_cnt == m_len - 1) m_act = 0;
            else m_cnt = (m_cnt + 1) % ROW;
        end
        @(posedge clk);
        @(negedge clk);
        tag = !m_act ? "R5" : (m_len == 0 ? "R6" : (m_ilv ? "R4" : "R3"));
        check({tag, " active"}, int'(burst_active), int'(m_act));
        check({tag, " addr"}, int'(col_addr), exp_col());
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int seqv[4];
        int ilvv[8];
        void'($urandom(32'd20240611));
        rst_n = 1'b0; burst_go = 0; burst_stop = 0;
        start_col = '0; bl_sel = '0; ilv_mode = 0;
        m_act = 0; m_cnt = 0; m_base = 0; m_len = 1; m_ilv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 active in reset", int'(burst_active), 0);
        check("R1 addr in reset", int'(col_addr), 0);
        rst_n = 1'b1;
        idle(1);
        check("R1 active after reset", int'(burst_active), 0);

        // R2/R3: sequential length 4 from column 5
        seqv = '{5, 6, 7, 4};
        step(1, 0, 5, 2, 0);
        check("R2 first col", int'(col_addr), 5);
        for (int i = 1; i < 4; i++) begin
            step(0, 0, 0, 0, 0);
            check("R3 seq wrap", int'(col_addr), seqv[i]);
        end
        step(0, 0, 0, 0, 0);
        check("R5 end after 4", int'(burst_active), 0);

        // R4: interleave length 8 from column 5
        ilvv = '{5, 4, 7, 6, 1, 0, 3, 2};
        step(1, 0, 5, 3, 1);
        for (int i = 0; i < 8; i++) begin
            if (i > 0) step(0, 0, 0, 0, 0);
            check("R4 ilv order", int'(col_addr), ilvv[i]);
        end
        step(0, 0, 0, 0, 0);
        check("R5 end after 8", int'(burst_active), 0);

        // R5: length 1
        step(1, 0, 77, 0, 0);
        check("R5 len1 col", int'(col_addr), 77);
        step(0, 0, 0, 0, 0);
        check("R5 len1 end", int'(burst_active), 0);

        // R6: full page across the row end, then stop (R8)
        step(1, 0, 254, 7, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        check("R6 page wrap", int'(col_addr), 0);
        for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 0);
        check("R6 page keeps going", int'(burst_active), 1);
        step(0, 1, 0, 0, 0);
        check("R8 stop ends", int'(burst_active), 0);
        step(0, 1, 0, 0, 0);
        check("R8 stop idle", int'(col_addr), 0);

        // R7: full page code with interleave behaves as length 8
        step(1, 0, 9, 5, 1);
        step(0, 0, 0, 0, 0);
        check("R7 ilv page", int'(col_addr), 8);
        idle(7);
        check("R7 ends after 8", int'(burst_active), 0);

        // R9: restart mid-burst, start beats stop
        step(1, 0, 16, 3, 0);
        step(0, 0, 0, 0, 0);
        step(1, 1, 42, 1, 0);
        check("R9 restart col", int'(col_addr), 42);
        check("R9 go beats stop", int'(burst_active), 1);
        step(0, 0, 0, 0, 0);
        check("R9 restart len2 step", int'(col_addr), 43);

        // R10: settings changed mid-burst are ignored
        step(1, 0, 2, 2, 0);
        step(0, 0, 0, 7, 1);
        check("R10 order held", int'(col_addr), 3);
        step(0, 0, 0, 7, 1);
        step(0, 0, 0, 7, 1);
        check("R10 length held", int'(col_addr), 1);
        step(0, 0, 0, 7, 1);
        check("R10 ends at 4", int'(burst_active), 0);

        // Random traffic
        for (int i = 0; i < 20000; i++) begin
            bit go, stop;
            go   = ($urandom % 12) == 0;
            stop = ($urandom % 30) == 0;
            step(go, stop, int'($urandom % ROW), int'($urandom % 8),
                 bit'($urandom % 2));
        end
        finish_run();
    end

endmodule